// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit carries out the memory-access step of a simple processor pipeline. For each request it receives a 32-bit base register value, a signed 16-bit displacement, the store data and a two-bit operation code. The operation is one of four: byte load, byte store, word load or word store. It adds the base and the sign-extended displacement to form the effective address. It then drives a word-organised, byte-laned data memory with one chip-select per byte lane and a shared write-enable.

Responses come back one cycle after the request. The response carries a done pulse, the load result for the register file, and a bus-error flag. The bus-error flag is raised when a word access lands on an address that is not a multiple of four. Such a faulting access never reaches memory. Byte loads are sign-extended unless the unsigned option is given, in which case they are zero-extended. Words are big-endian: the byte at the lowest address sits in bits 31:24.

Top module: `lsu_top`

## Requirements
- R1: The effective address is `base + sign_extend(offset)` modulo 2^32, and `mem_waddr` presents bits 31:2 of it during the request cycle.
- R2: A byte store asserts `mem_we` and exactly one chip-select bit, `mem_cs[3 - ea[1:0]]`. It writes `wdata[7:0]` into that lane and leaves the other three bytes of the word unchanged.
- R3: A byte load with `req_unsigned` low returns the addressed byte sign-extended to 32 bits.
- R4: A byte load with `req_unsigned` high returns the addressed byte zero-extended to 32 bits.
- R5: Word accesses are big-endian. Lane `mem_cs[3]` (data bits 31:24) is address offset 0 and `mem_cs[0]` (bits 7:0) is offset 3. An aligned word access asserts all four chip-selects, and a word load returns the four bytes in that order.
- R6: A word access whose effective address has nonzero bits 1:0 asserts no chip-select and no write-enable. It raises `bus_err` in its done cycle with `ld_data` equal to zero, and memory is unchanged.
- R7: Byte accesses never raise `bus_err`, at any alignment.
- R8: `done` pulses for exactly the one cycle after each cycle with `req_valid` high. `ld_data` carries the load result in that cycle and is zero in every other cycle and for stores.
- R9: With `req_valid` low, all chip-selects and the write-enable are low.
- R10: After reset, `done`, `bus_err` and `ld_data` are all zero.

Operation codes on `req_op`: 2'b00 byte load, 2'b01 byte store, 2'b10 word load, 2'b11 word store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code: bit 1 word size, bit 0 store |
| req_unsigned | input | 1 | Zero-extend byte loads instead of sign-extending |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data from the source register |
| mem_cs | output | 4 | Per-lane chip-selects, bit 3 = lowest byte address |
| mem_we | output | 1 | Write-enable, qualified by the chip-selects |
| mem_waddr | output | 30 | Word address (effective address bits 31:2) |
| mem_wdata | output | 32 | Store data placed on the byte lanes |
| mem_rdata | input | 32 | Read word, registered by memory, valid the cycle after a read |
| ld_data | output | 32 | Load result for the register file |
| done | output | 1 | One-cycle response pulse |
| bus_err | output | 1 | Misaligned word access, valid with done |

## Verification
The memory-side outputs (`mem_cs`, `mem_we`, `mem_waddr`, `mem_wdata`) respond combinationally in the request cycle. The bench drives a request just after a falling edge and samples these a time step later, before the rising edge. `done`, `bus_err` and `ld_data` are due one rising edge later: the memory model registers the read word at that edge, and the unit registers its response at the same edge. The bench samples them at the next falling edge and confirms at the falling edge after that that `done` has dropped again. Store effects are checked in the bench's own byte array, and also through later word loads.

// File: rtl/lsu_pkg.sv
// Package: shared operation codes and helpers for the load/store unit.
// Assumes bit 1 of the code selects word size and bit 0 selects a store.
package lsu_pkg;

    typedef enum logic [1:0] {
        OP_LDB = 2'b00,
        OP_STB = 2'b01,
        OP_LDW = 2'b10,
        OP_STW = 2'b11
    } lsu_op_e;

    // True when the operation moves a full word.
    function automatic logic op_is_word(input lsu_op_e op);
        return op[1];
    endfunction

    // True when the operation writes memory.
    function automatic logic op_is_store(input lsu_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Address generator: adds base and sign-extended displacement, splits the
// result into word address and byte lane, and flags misaligned word access.
// Assumes OFF_W < ADDR_W and a power-of-two lane count.
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = 4,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFF_W-1:0]    offset,
    input  logic                is_word,
    output logic [ADDR_W-LSW-1:0] waddr,
    output logic [LSW-1:0]      lane,
    output logic                fault
);

    logic [ADDR_W-1:0] ea;

    // Effective address: modulo-2^ADDR_W sum with sign-extended offset.
    always_comb begin
        ea    = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        waddr = ea[ADDR_W-1:LSW];
        lane  = ea[LSW-1:0];
        fault = is_word && (lane != '0);
    end

endmodule

// File: rtl/lsu_lane_ctl.sv
// Lane control: turns one request into per-lane chip-selects, a write-enable
// and lane-positioned store data. Lane bit i covers data bits 8i+7:8i,
// which is byte offset LANES-1-i (big-endian). Faulting requests stay off.
module lsu_lane_ctl #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              is_word,
    input  logic              is_store,
    input  logic              fault,
    input  logic [LSW-1:0]    lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  cs,
    output logic              we,
    output logic [DATA_W-1:0] lane_wdata
);

    logic go;

    // Request reaches memory only when present and not faulting.
    always_comb go = valid && !fault;

    // Write-enable follows the store flag of a live request.
    always_comb we = go && is_store;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Select this lane for words, or when it holds the addressed byte.
        always_comb cs[g] = go && (is_word || (lane == LSW'(LANES-1-g)));
        // Word stores place their own byte; byte stores replicate bits 7:0.
        always_comb lane_wdata[8*g +: 8] = is_word ? wdata[8*g +: 8] : wdata[7:0];
    end

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_word) |-> ($countones(cs) == 1)); // R2
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && is_word && (lane != '0)) |-> (cs == '0 && !we)); // R6

endmodule

// File: rtl/lsu_load_fmt.sv
// Load formatter: picks the addressed byte from the registered memory word
// and extends it, or passes the whole word. Output is zero when inactive.
// Assumes the memory word is big-endian across lanes.
module lsu_load_fmt #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic              active,
    input  logic              is_word,
    input  logic              is_unsigned,
    input  logic [LSW-1:0]    lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);

    logic [7:0] pick;

    // Byte select: lane bit i holds byte offset LANES-1-i.
    always_comb begin
        pick = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LSW'(LANES-1-i)) pick = rdata[8*i +: 8];
        end
    end

    // Result: whole word, zero-extended byte or sign-extended byte.
    always_comb begin
        if (!active)          result = '0;
        else if (is_word)     result = rdata;
        else if (is_unsigned) result = {{(DATA_W-8){1'b0}}, pick};
        else                  result = {{(DATA_W-8){pick[7]}}, pick};
    end

endmodule

// File: rtl/lsu_top.sv
// Load/store unit top: address generation and lane control in the request
// cycle, one response register stage, load formatting in the done cycle.
// Assumes a memory that registers its read word at the request edge.
module lsu_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    localparam int LANES = DATA_W / 8,
    localparam int LSW   = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic                  req_unsigned,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [OFF_W-1:0]      req_offset,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic [LANES-1:0]      mem_cs,
    output logic                  mem_we,
    output logic [ADDR_W-LSW-1:0] mem_waddr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     ld_data,
    output logic                  done,
    output logic                  bus_err
);
    import lsu_pkg::*;

    lsu_op_e        op;
    logic           is_word, is_store, fault;
    logic [LSW-1:0] lane;

    logic           rsp_done, rsp_err, rsp_load, rsp_word, rsp_uns;
    logic [LSW-1:0] rsp_lane;

    // Decode the operation code into size and direction.
    always_comb begin
        op       = lsu_op_e'(req_op);
        is_word  = op_is_word(op);
        is_store = op_is_store(op);
    end

    lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
        .base    (req_base),
        .offset  (req_offset),
        .is_word (is_word),
        .waddr   (mem_waddr),
        .lane    (lane),
        .fault   (fault)
    );

    lsu_lane_ctl #(.DATA_W(DATA_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (req_valid),
        .is_word    (is_word),
        .is_store   (is_store),
        .fault      (fault),
        .lane       (lane),
        .wdata      (req_wdata),
        .cs         (mem_cs),
        .we         (mem_we),
        .lane_wdata (mem_wdata)
    );

    // Response stage: capture what the done cycle needs to format a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_load <= 1'b0;
            rsp_word <= 1'b0;
            rsp_uns  <= 1'b0;
            rsp_lane <= '0;
        end else begin
            rsp_done <= req_valid;
            rsp_err  <= req_valid && fault;
            rsp_load <= req_valid && !is_store && !fault;
            rsp_word <= is_word;
            rsp_uns  <= req_unsigned;
            rsp_lane <= lane;
        end
    end

    lsu_load_fmt #(.DATA_W(DATA_W)) u_fmt (
        .active      (rsp_done && rsp_load),
        .is_word     (rsp_word),
        .is_unsigned (rsp_uns),
        .lane        (rsp_lane),
        .rdata       (mem_rdata),
        .result      (ld_data)
    );

    // Response outputs.
    always_comb begin
        done    = rsp_done;
        bus_err = rsp_err;
    end

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R8
    AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid)); // R8
    AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (ld_data == '0)); // R8
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(mem_cs) == '0 && !$past(mem_we))); // R6
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (ld_data == '0)); // R6
    AST_BYTE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1]) |=> !bus_err); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_cs == '0 && !mem_we)); // R9
    AST_WE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_valid && req_op[0])); // R2

endmodule

// File: tb/tb_lsu_top.sv
`timescale 1ns/1ps
module tb_lsu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  mem_cs;
    logic        mem_we;
    logic [29:0] mem_waddr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] ld_data;
    logic        done, bus_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] bytes [0:255];

    // Results captured by the access task.
    logic [3:0]  s_cs;
    logic        s_we;
    logic [29:0] s_wa;
    logic [31:0] s_ld;
    logic        s_err, s_done, s_done_after;

    always #5 clk = ~clk;

    lsu_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_unsigned(req_unsigned), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_data(ld_data), .done(done), .bus_err(bus_err)
    );

    // Byte-array memory, lane bit i = byte offset 3-i, read word registered.
    always @(posedge clk) begin
        if (|mem_cs) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_cs[i]) bytes[{mem_waddr[5:0], 2'(3 - i)}] <= mem_wdata[8*i +: 8];
            end else begin
                mem_rdata <= {bytes[{mem_waddr[5:0], 2'd0}], bytes[{mem_waddr[5:0], 2'd1}],
                              bytes[{mem_waddr[5:0], 2'd2}], bytes[{mem_waddr[5:0], 2'd3}]};
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: drive after a falling edge, sample memory side before the
    // rising edge, response at the next falling edge, idle one cycle later.
    task automatic access(input logic [1:0] op, input logic uns, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_unsigned = uns;
        req_base = base; req_offset = off; req_wdata = wd;
        #1;
        s_cs = mem_cs; s_we = mem_we; s_wa = mem_waddr;
        @(negedge clk);
        req_valid = 1'b0;
        s_ld = ld_data; s_err = bus_err; s_done = done;
        @(negedge clk);
        s_done_after = done;
    endtask

    task automatic t_reset;
        check("R10 done", 32'(done), 32'h0);
        check("R10 bus_err", 32'(bus_err), 32'h0);
        check("R10 ld_data", ld_data, 32'h0);
        check("R9 idle cs", 32'(mem_cs), 32'h0);
    endtask

    task automatic t_word_store;
        access(2'b11, 1'b0, 32'h0000_0020, 16'hFFF0, 32'hA1B2_C3D4);
        check("R1 waddr neg offset", 32'(s_wa), 32'h4);
        check("R5 word store cs", 32'(s_cs), 32'hF);
        check("R5 word store we", 32'(s_we), 32'h1);
        check("R5 byte order", {bytes[16], bytes[17], bytes[18], bytes[19]}, 32'hA1B2_C3D4);
        check("R8 store done", 32'(s_done), 32'h1);
        check("R8 store ld zero", s_ld, 32'h0);
        check("R8 done one cycle", 32'(s_done_after), 32'h0);
    endtask

    task automatic t_word_load;
        access(2'b10, 1'b0, 32'h0000_0010, 16'h0000, 32'h0);
        check("R5 word load", s_ld, 32'hA1B2_C3D4);
        check("R8 load done", 32'(s_done), 32'h1);
        check("R8 ld zero after", ld_data, 32'h0);
    endtask

    task automatic t_byte_store;
        access(2'b01, 1'b0, 32'h0000_0010, 16'h0003, 32'h1234_56A5);
        check("R2 one lane", 32'(s_cs), 32'h1);
        check("R2 byte written", 32'(bytes[19]), 32'hA5);
        check("R2 neighbours kept", {8'h0, bytes[16], bytes[17], bytes[18]}, 32'h00A1_B2C3);
        check("R7 byte store no err", 32'(s_err), 32'h0);
    endtask

    task automatic t_byte_loads;
        access(2'b00, 1'b0, 32'h0000_0013, 16'h0000, 32'h0);
        check("R3 signed neg byte", s_ld, 32'hFFFF_FFA5);
        access(2'b00, 1'b1, 32'h0000_0013, 16'h0000, 32'h0);
        check("R4 unsigned byte", s_ld, 32'h0000_00A5);
        access(2'b01, 1'b0, 32'h0000_0021, 16'h0000, 32'hFFFF_FF5A);
        access(2'b00, 1'b0, 32'h0000_0021, 16'h0000, 32'h0);
        check("R3 signed pos byte", s_ld, 32'h0000_005A);
        check("R2 lane for offset 1", 32'(s_cs), 32'h4);
        check("R7 odd byte no err", 32'(s_err), 32'h0);
        access(2'b00, 1'b0, 32'h0000_0010, 16'h0002, 32'h0);
        check("R3 offset 2 byte", s_ld, 32'hFFFF_FFC3);
    endtask

    task automatic t_misaligned;
        access(2'b10, 1'b0, 32'h0000_0010, 16'h0002, 32'h0);
        check("R6 load no cs", 32'(s_cs), 32'h0);
        check("R6 load err", 32'(s_err), 32'h1);
        check("R6 load zero", s_ld, 32'h0);
        access(2'b11, 1'b0, 32'h0000_0011, 16'h0000, 32'hFFFF_FFFF);
        check("R6 store no cs/we", {27'h0, s_we, s_cs}, 32'h0);
        check("R6 store err", 32'(s_err), 32'h1);
        check("R6 memory kept", {bytes[16], bytes[17], bytes[18], bytes[19]}, 32'hA1B2_C3A5);
    endtask

    task automatic t_address_wrap;
        access(2'b10, 1'b0, 32'hFFFF_FFF0, 16'h0020, 32'h0);
        check("R1 wrap waddr", 32'(s_wa), 32'h4);
        check("R1 wrap load", s_ld, 32'hA1B2_C3A5);
        access(2'b00, 1'b0, 32'h1234_5678, 16'hFFF8, 32'h0);
        check("R1 large waddr", 32'(s_wa), 32'h048D_159C);
        check("R1 large lane", 32'(s_cs), 32'h8);
        check("R9 idle after", {27'h0, mem_we, mem_cs}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bytes[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_store();
        t_word_load();
        t_byte_store();
        t_byte_loads();
        t_misaligned();
        t_address_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule